// File: doc/BRIEF.md
# Inductor-Current Capacitor Balancing Compensator

In a three-level boost stage with two stacked output capacitors, the mismatch between the two capacitor voltages shows up in the inductor current ripple. If the current is sampled at two points placed symmetrically about the carrier peak, the difference between those two samples is proportional to the voltage mismatch. This block takes the ADC samples of the inductor current together with three sample strobes from the PWM timer. It holds one sample taken at the carrier peak, which is the average current for the outer current loop. It also holds two mid-slope samples, one on the rising half and one on the falling half of the carrier.

Once all three samples of a period have been captured, the block subtracts the rising-side sample from the falling-side sample. It multiplies that difference by an unsigned fractional gain, rounds the product and adds it to the primary switch's duty command. The sum is saturated and becomes the second switch's duty command. The new command is held back and changes only at the next carrier-valley strobe, so a PWM period never sees its duty change partway through. For a stable loop the gain stays small and positive. A typical setting is around 0.05, which is about 3277 in the gain format.

Top module: `cap_balance_comp`

## Requirements
- R1: A sample presented together with the peak strobe appears on `avg_cur` one clock later and is held until the next peak strobe.
- R2: A sample presented with the rising-mid strobe is held as the first mid sample, and a sample presented with the falling-mid strobe is held as the second. Each is replaced only by its own strobe.
- R3: `diff_cur` = second mid sample − first mid sample, as a 13-bit signed value. A positive value means the lower capacitor sits above the upper one. It updates one clock after the cycle in which all three samples are first held.
- R4: Compensation = floor((diff × gain + 32768) / 65536), where `gain` is an unsigned value with 16 fraction bits. The result before saturation is `duty_pri` + compensation, with `duty_pri` taken in the cycle after `diff_cur` updates.
- R5: A computation starts only when the peak, rising-mid and falling-mid strobes have each occurred since the previous computation. With any one of them missing, `done` stays low and `duty_sec` does not change.
- R6: `duty_sec` changes only at a clock edge where `strb_valley` is high, and only if a result has been computed and not yet loaded. A valley strobe with nothing pending leaves it unchanged.
- R7: `duty_sec` is saturated: a negative sum gives 0 and a sum above 65535 gives 65535.
- R8: Reset clears the held samples, `diff_cur`, `duty_sec`, `done` and `valid` to zero.
- R9: `done` is a one-clock pulse two clocks after `diff_cur` updates. `valid` rises with the first `done` and stays high until reset.
- R10: With `gain` = 0 the loaded `duty_sec` equals `duty_pri`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 12 | Signed inductor-current ADC sample |
| strb_peak | input | 1 | Sample strobe at carrier peak |
| strb_rise | input | 1 | Sample strobe at rising mid-crossing |
| strb_fall | input | 1 | Sample strobe at falling mid-crossing |
| strb_valley | input | 1 | Carrier valley, load point for `duty_sec` |
| duty_pri | input | 16 | Primary switch duty command, unsigned full scale |
| gain | input | 16 | Proportional gain, unsigned, 16 fraction bits |
| avg_cur | output | 12 | Held peak (average) current sample |
| diff_cur | output | 13 | Falling-mid minus rising-mid sample |
| duty_sec | output | 16 | Second switch duty command |
| done | output | 1 | One-clock pulse after each computation |
| valid | output | 1 | Sticky flag: a result has been produced |

## Verification
The bench drives a table of periods with positive and negative differences, several gains and values that need rounding, and predicts each loaded command from the rounding rule. If the subtraction were swapped, the correction would take the wrong sign. If rounding were a plain truncation, results would be off by one on half-LSB cases. Full-scale opposite-sign samples near the ends of the duty range check the clamp; a design that wrapped would return a tiny duty for a large one or the reverse. Other cases send a valley strobe before a result exists, and run a period missing two of its strobes. They catch a design that loads early, reloads stale data, or starts the computation before all three samples are in.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef struct packed {
    logic peak;
    logic rise;
    logic fall;
  } strb_t;

  localparam int FLG_PEAK = 2;
  localparam int FLG_RISE = 1;
  localparam int FLG_FALL = 0;
endpackage

// File: rtl/cbc_sample_hold.sv
module cbc_sample_hold #(
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] smp,
  input  cbc_pkg::strb_t       stb,
  output logic signed [SW-1:0] avg_q,
  output logic signed [SW-1:0] mid1_q,
  output logic signed [SW-1:0] mid2_q,
  output logic                 all_seen
);
  logic [2:0] seen_q, seen_d;
  logic signed [SW-1:0] avg_d, mid1_d, mid2_d;
  logic [2:0] stb_vec;

  assign stb_vec  = {stb.peak, stb.rise, stb.fall};
  assign all_seen = &seen_q;

  always_comb begin
    avg_d  = avg_q;
    mid1_d = mid1_q;
    mid2_d = mid2_q;
    if (stb.peak) avg_d  = smp;
    if (stb.rise) mid1_d = smp;
    if (stb.fall) mid2_d = smp;
    seen_d = (all_seen ? 3'b000 : seen_q) | stb_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q  <= '0;
      mid1_q <= '0;
      mid2_q <= '0;
      seen_q <= '0;
    end else begin
      if (stb.peak) avg_q  <= avg_d;
      if (stb.rise) mid1_q <= mid1_d;
      if (stb.fall) mid2_q <= mid2_d;
      seen_q <= seen_d;
    end
  end

  p_avg_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb.peak |=> avg_q == $past(smp));
  p_mid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.rise |=> $stable(mid1_q));
endmodule

// File: rtl/cbc_prop_mac.sv
module cbc_prop_mac #(
  parameter int SW = 12,
  parameter int GW = 16,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [SW-1:0] mid1,
  input  logic signed [SW-1:0] mid2,
  input  logic [DW-1:0]        duty_pri,
  input  logic [GW-1:0]        gain,
  output logic signed [SW:0]   diff_q,
  output logic [DW-1:0]        res_q,
  output logic                 res_v
);
  localparam int DFW  = SW + 1;
  localparam int PW   = DFW + GW + 1;
  localparam int SUMW = PW + DW;
  localparam logic signed [PW-1:0]   HALF = PW'(1) <<< (GW - 1);
  localparam logic signed [SUMW-1:0] FULL = SUMW'((64'd1 << DW) - 64'd1);

  logic                   go_q;
  logic signed [DFW-1:0]  diff_d;
  logic signed [PW-1:0]   prod, rnd, comp;
  logic signed [SUMW-1:0] sum;
  logic [DW-1:0]          res_d;

  always_comb begin
    diff_d = {mid2[SW-1], mid2} - {mid1[SW-1], mid1};
    prod   = $signed({{DFW{1'b0}}, 1'b0, gain}) *
             $signed({{(GW+1){diff_q[DFW-1]}}, diff_q});
    rnd    = prod + HALF;
    comp   = rnd >>> GW;
    sum    = $signed({{PW{1'b0}}, duty_pri}) + $signed({{DW{comp[PW-1]}}, comp});
    if (sum < 0)         res_d = '0;
    else if (sum > FULL) res_d = '1;
    else                 res_d = sum[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= '0;
      go_q   <= 1'b0;
      res_q  <= '0;
      res_v  <= 1'b0;
    end else begin
      go_q  <= start;
      res_v <= go_q;
      if (start) diff_q <= diff_d;
      if (go_q)  res_q  <= res_d;
    end
  end

  p_comp_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_v && ($past(diff_q) > 0) |-> res_q >= $past(duty_pri));
  p_comp_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_v && ($past(diff_q) < 0) |-> res_q <= $past(duty_pri));
  p_diff_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(diff_q) |-> $past(start));
endmodule

// File: rtl/cbc_valley_load.sv
module cbc_valley_load #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_v,
  input  logic [DW-1:0] res,
  input  logic          valley,
  output logic [DW-1:0] duty_q,
  output logic          done_q,
  output logic          valid_q
);
  logic pend_q, pend_d, load;

  always_comb begin
    load   = valley && pend_q;
    pend_d = pend_q;
    if (load)  pend_d = 1'b0;
    if (res_v) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      done_q <= res_v;
      pend_q <= pend_d;
      if (res_v) valid_q <= 1'b1;
      if (load)  duty_q  <= res;
    end
  end

  p_load_at_valley_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> $past(valley));
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> valid_q);
endmodule

// File: rtl/cap_balance_comp.sv
module cap_balance_comp #(
  parameter int SW = 12,
  parameter int GW = 16,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] smp_data,
  input  logic                 strb_peak,
  input  logic                 strb_rise,
  input  logic                 strb_fall,
  input  logic                 strb_valley,
  input  logic [DW-1:0]        duty_pri,
  input  logic [GW-1:0]        gain,
  output logic signed [SW-1:0] avg_cur,
  output logic signed [SW:0]   diff_cur,
  output logic [DW-1:0]        duty_sec,
  output logic                 done,
  output logic                 valid
);
  cbc_pkg::strb_t       stb;
  logic signed [SW-1:0] mid1, mid2;
  logic                 all_seen, res_v;
  logic [DW-1:0]        res;

  assign stb = '{peak: strb_peak, rise: strb_rise, fall: strb_fall};

  cbc_sample_hold #(.SW(SW)) u_hold (
    .clk(clk), .rst_n(rst_n), .smp(smp_data), .stb(stb),
    .avg_q(avg_cur), .mid1_q(mid1), .mid2_q(mid2), .all_seen(all_seen)
  );

  cbc_prop_mac #(.SW(SW), .GW(GW), .DW(DW)) u_mac (
    .clk(clk), .rst_n(rst_n), .start(all_seen), .mid1(mid1), .mid2(mid2),
    .duty_pri(duty_pri), .gain(gain), .diff_q(diff_cur), .res_q(res), .res_v(res_v)
  );

  cbc_valley_load #(.DW(DW)) u_load (
    .clk(clk), .rst_n(rst_n), .res_v(res_v), .res(res), .valley(strb_valley),
    .duty_q(duty_sec), .done_q(done), .valid_q(valid)
  );

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(all_seen, 3));
endmodule

// File: tb/cap_balance_comp_tb_top.sv
module cap_balance_comp_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic signed [11:0] smp_data;
  logic strb_peak, strb_rise, strb_fall, strb_valley;
  logic [15:0] duty_pri, gain;
  logic signed [11:0] avg_cur;
  logic signed [12:0] diff_cur;
  logic [15:0] duty_sec;
  logic done, valid;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cap_balance_comp dut_i (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .strb_peak(strb_peak),
    .strb_rise(strb_rise), .strb_fall(strb_fall), .strb_valley(strb_valley),
    .duty_pri(duty_pri), .gain(gain), .avg_cur(avg_cur), .diff_cur(diff_cur),
    .duty_sec(duty_sec), .done(done), .valid(valid)
  );

  // rising sample, falling sample, peak sample, primary duty, gain
  localparam int VEC [6][5] = '{
    '{100, 300, 200, 30000, 3277},
    '{500, -120, 50, 20000, 6554},
    '{-7, 9, 0, 1000, 32768},
    '{-2048, 2047, 1000, 65530, 65535},
    '{2047, -2048, -1000, 100, 65535},
    '{-300, 700, 12, 4321, 0}
  };

  function automatic int exp_sec(int a, int b, int pri, int g);
    longint d = longint'(b) - longint'(a);
    longint c = (d * longint'(g) + 64'sd32768) >>> 16;
    longint s = longint'(pri) + c;
    if (s < 0) return 0;
    if (s > 65535) return 65535;
    return int'(s);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit pk, bit rs, bit fl, bit vl, int d);
    strb_peak = pk; strb_rise = rs; strb_fall = fl; strb_valley = vl;
    smp_data = 12'(d);
  endtask

  task automatic period(int a, int b, int c, int pri, int g);
    duty_pri = 16'(pri); gain = 16'(g);
    drive(0, 1, 0, 0, a); step();
    drive(0, 0, 1, 0, b); step();
    drive(1, 0, 0, 0, c); step();
    check("R1 avg", int'(avg_cur), c);
    drive(0, 0, 0, 0, 0); step();
    check("R3 diff", int'(diff_cur), b - a);
    step();
    check("R9 done low before", int'(done), 0);
    step();
    check("R9 done pulse", int'(done), 1);
    drive(0, 0, 0, 1, 0); step();
    drive(0, 0, 0, 0, 0);
    check("R4 R7 R10 duty_sec", int'(duty_sec), exp_sec(a, b, pri, g));
    check("R9 done cleared", int'(done), 0);
    check("R9 valid", int'(valid), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    duty_pri = '0; gain = '0;
    step(); step();
    check("R8 reset duty", int'(duty_sec), 0);
    check("R8 reset valid", int'(valid), 0);
    check("R8 reset avg", int'(avg_cur), 0);
    rst_n = 1'b1;
    step();
    drive(0, 0, 0, 1, 0); step(); drive(0, 0, 0, 0, 0);
    check("R6 valley with nothing pending", int'(duty_sec), 0);

    foreach (VEC[i]) period(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

    // incomplete period: only rising strobe then valley
    duty_pri = 16'd5000; gain = 16'd3277;
    drive(0, 1, 0, 0, 800); step();
    drive(0, 0, 0, 0, 0); step(); step(); step();
    check("R5 no done on partial", int'(done), 0);
    drive(0, 0, 0, 1, 0); step(); drive(0, 0, 0, 0, 0);
    check("R5 R6 duty unchanged", int'(duty_sec), exp_sec(-300, 700, 4321, 0));
    check("R2 avg held", int'(avg_cur), 12);
    check("R2 diff held", int'(diff_cur), 1000);
    // finish the period with falling and peak, using the new rising sample
    period(800, 900, 33, 5000, 3277);

    rst_n = 1'b0; step();
    check("R8 mid reset diff", int'(diff_cur), 0);
    check("R8 mid reset duty", int'(duty_sec), 0);
    check("R8 mid reset valid", int'(valid), 0);
    rst_n = 1'b1;
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule